// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block collects 64 level-driven interrupt sources and presents them to a processor on two request lines. One line serves ordinary interrupts, and its output is gated by a priority threshold. The other line serves fast interrupts and has no threshold. Every source has four pieces of state:

- a pending bit;
- an enable bit;
- a type bit that selects fast or normal;
- a 4-bit priority.

Software reaches all of this state through a 32-bit port that is addressed by word index. Read data comes back one cycle after the read.

Two read-only vector words report the winning source on each line. Reading either word also acknowledges that source and clears its pending bit, so an interrupt handler needs one read to find the source and retire it. Enables can be changed one source at a time by writing a source number. A force register lets software overwrite the pending vector directly.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the pending, enable, type, control and priority state are all zero, the threshold mask reads 0x1F, and both request outputs are low.
- R2: A write to index 2 sets the enable bit numbered by data bits [5:0]. A write to index 3 clears that bit. Both indices read as zero.
- R3: Indices 4/5 read and write enables [63:32]/[31:0]. Indices 6/7 do the same for the type bits, where 1 means fast.
- R4: Source s has its priority in nibble (s mod 8) of a priority word. Index 15 holds the word for sources 0–7, and each lower index holds the next eight sources, down to index 8 for sources 56–63.
- R5: A write to index 20 or 21 overwrites pending [63:32] or [31:0]. Both indices read zero. Indices 18/19 return pending [63:32]/[31:0].
- R6: On a source input, a rising level sets the pending bit and a falling level clears it. A level held high sets the bit again on the cycle after an acknowledge. If an acknowledge and a level change hit the same bit in the same cycle, the acknowledge wins.
- R7: The threshold mask at index 1 is 5 bits wide. When it is 0x1F, the normal output is high for any pending, enabled, normal source. Otherwise the output is high only for such a source whose priority is strictly greater than the mask.
- R8: A read of index 16 returns (source << 16) | priority for the pending, enabled normal source with the highest priority. A tie goes to the higher source number. The read clears that source's pending bit. If there is no such source, the read returns 0xFFFFFFFF.
- R9: A read of index 17 returns the lowest-numbered pending, enabled fast source and clears its pending bit, or returns 0xFFFFFFFF if there is none. The fast output is high while any such source exists.
- R10: Indices 16–19 and 22–25 ignore writes. Indices 22/23 return pending & enable & ~type, and indices 24/25 return pending & enable & type, high half first.
- R11: A read of index 64 returns 4. Writes to indices 64–191 have no effect. Unmapped reads return 0.
- R12: Read data appears on the data output in the cycle after the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLevel | input | 64 | Source request levels |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busIdx | input | 8 | Word index (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
In one clock cycle, the pending bit of a source can receive both a change from its input level and a clear from a vector-read acknowledge. The bench provokes this case by forcing a source pending while its input is low. It then raises that input in the same cycle as the vector read that acknowledges the source. The bench judges the outcome through back-to-back source reads: the first must show the bit cleared, because the acknowledge wins, and the second must show it set again, because the level is still high. The same pair of reads checks that a held source comes back after a plain acknowledge.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int IDX_W = 8;

  localparam logic [IDX_W-1:0] IX_CNTL    = 8'd0;
  localparam logic [IDX_W-1:0] IX_MASK    = 8'd1;
  localparam logic [IDX_W-1:0] IX_ENNUM   = 8'd2;
  localparam logic [IDX_W-1:0] IX_DISNUM  = 8'd3;
  localparam logic [IDX_W-1:0] IX_ENHI    = 8'd4;
  localparam logic [IDX_W-1:0] IX_ENLO    = 8'd5;
  localparam logic [IDX_W-1:0] IX_TYHI    = 8'd6;
  localparam logic [IDX_W-1:0] IX_TYLO    = 8'd7;
  localparam logic [IDX_W-1:0] IX_NVEC    = 8'd16;
  localparam logic [IDX_W-1:0] IX_FVEC    = 8'd17;
  localparam logic [IDX_W-1:0] IX_SRCHI   = 8'd18;
  localparam logic [IDX_W-1:0] IX_SRCLO   = 8'd19;
  localparam logic [IDX_W-1:0] IX_FRCHI   = 8'd20;
  localparam logic [IDX_W-1:0] IX_FRCLO   = 8'd21;
  localparam logic [IDX_W-1:0] IX_NPNDHI  = 8'd22;
  localparam logic [IDX_W-1:0] IX_NPNDLO  = 8'd23;
  localparam logic [IDX_W-1:0] IX_FPNDHI  = 8'd24;
  localparam logic [IDX_W-1:0] IX_FPNDLO  = 8'd25;
  localparam logic [IDX_W-1:0] IX_VECBASE = 8'd64;

  localparam logic [31:0] VEC_BASE_VALUE = 32'd4;
  localparam logic [31:0] NO_WINNER      = 32'hFFFF_FFFF;

  typedef struct packed {
    logic wrCntl;
    logic wrMask;
    logic wrEnNum;
    logic wrDisNum;
    logic wrEnHi;
    logic wrEnLo;
    logic wrTypeHi;
    logic wrTypeLo;
    logic wrPrio;
    logic wrForceHi;
    logic wrForceLo;
    logic rdEn;
    logic ackNorm;
    logic ackFast;
  } vicStrobes_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic             busSel,
  input  logic             busWr,
  input  logic [IDX_W-1:0] busIdx,
  output vicStrobes_t      stb
);
  always_comb begin
    stb = '0;
    if (busSel && busWr) begin
      case (busIdx)
        IX_CNTL:   stb.wrCntl    = 1'b1;
        IX_MASK:   stb.wrMask    = 1'b1;
        IX_ENNUM:  stb.wrEnNum   = 1'b1;
        IX_DISNUM: stb.wrDisNum  = 1'b1;
        IX_ENHI:   stb.wrEnHi    = 1'b1;
        IX_ENLO:   stb.wrEnLo    = 1'b1;
        IX_TYHI:   stb.wrTypeHi  = 1'b1;
        IX_TYLO:   stb.wrTypeLo  = 1'b1;
        IX_FRCHI:  stb.wrForceHi = 1'b1;
        IX_FRCLO:  stb.wrForceLo = 1'b1;
        8'd8, 8'd9, 8'd10, 8'd11,
        8'd12, 8'd13, 8'd14, 8'd15: stb.wrPrio = 1'b1;
        default: ;
      endcase
    end else if (busSel) begin
      stb.rdEn    = 1'b1;
      stb.ackNorm = (busIdx == IX_NVEC);
      stb.ackFast = (busIdx == IX_FVEC);
    end
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  vicStrobes_t        stb,
  input  logic [IDX_W-1:0]   busIdx,
  input  logic [31:0]        busWdata,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic [31:0]        busRdata,
  output logic               irqOut,
  output logic               fiqOut
);
  localparam int HALF     = 32;
  localparam int PER_WORD = 32 / PRIO_W;
  localparam int NWORDS   = NUM_SRC / PER_WORD;
  localparam int WSEL_W   = $clog2(NWORDS);
  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int MASK_W   = PRIO_W + 1;
  localparam logic [MASK_W-1:0] MASK_ALL = '1;

  logic [NUM_SRC-1:0] pending, enabled, fastType, srcPrev, ackPrev;
  logic [NUM_SRC-1:0] pNext, ackVec, normFlags, fastFlags, overMask;
  logic [31:0]        cntlReg, rdMux;
  logic [MASK_W-1:0]  maskReg;
  logic [31:0]        prioWord [NWORDS];
  logic [PRIO_W-1:0]  prio [NUM_SRC];
  logic [WSEL_W-1:0]  wordSel;
  logic [SRC_W-1:0]   normBest, fastBest;
  logic [PRIO_W-1:0]  normBestPrio;
  logic               normFound, fastFound;

  // priority index 8 maps to the top word, index 15 to word 0
  assign wordSel = ~busIdx[WSEL_W-1:0];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
    assign prio[g]     = prioWord[g / PER_WORD][(g % PER_WORD) * PRIO_W +: PRIO_W];
    assign overMask[g] = {1'b0, prio[g]} > maskReg;
  end

  assign normFlags = pending & enabled & ~fastType;
  assign fastFlags = pending & enabled & fastType;
  assign fiqOut    = |fastFlags;
  assign irqOut    = (maskReg == MASK_ALL) ? |normFlags : |(normFlags & overMask);

  // normal winner: highest priority, later (higher) index wins ties
  always_comb begin
    normFound    = 1'b0;
    normBest     = '0;
    normBestPrio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (normFlags[i] && (!normFound || prio[i] >= normBestPrio)) begin
        normFound    = 1'b1;
        normBest     = SRC_W'(i);
        normBestPrio = prio[i];
      end
    end
  end

  // fast winner: lowest numbered source
  always_comb begin
    fastFound = 1'b0;
    fastBest  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (fastFlags[i]) begin
        fastFound = 1'b1;
        fastBest  = SRC_W'(i);
      end
    end
  end

  always_comb begin
    ackVec = '0;
    if (stb.ackNorm && normFound) ackVec[normBest] = 1'b1;
    if (stb.ackFast && fastFound) ackVec[fastBest] = 1'b1;
  end

  // level edges first, then software force, acknowledge last (wins)
  always_comb begin
    pNext = (pending | (srcLevel & ~srcPrev) | (ackPrev & srcLevel))
            & ~(~srcLevel & srcPrev);
    if (stb.wrForceHi) pNext[HALF +: HALF] = busWdata;
    if (stb.wrForceLo) pNext[0 +: HALF]    = busWdata;
    pNext = pNext & ~ackVec;
  end

  always_comb begin
    case (busIdx)
      IX_CNTL:   rdMux = cntlReg;
      IX_MASK:   rdMux = 32'(maskReg);
      IX_ENHI:   rdMux = enabled[HALF +: HALF];
      IX_ENLO:   rdMux = enabled[0 +: HALF];
      IX_TYHI:   rdMux = fastType[HALF +: HALF];
      IX_TYLO:   rdMux = fastType[0 +: HALF];
      8'd8, 8'd9, 8'd10, 8'd11,
      8'd12, 8'd13, 8'd14, 8'd15: rdMux = prioWord[wordSel];
      IX_NVEC:   rdMux = normFound ? {{(16-SRC_W){1'b0}}, normBest,
                                      {(16-PRIO_W){1'b0}}, normBestPrio} : NO_WINNER;
      IX_FVEC:   rdMux = fastFound ? 32'(fastBest) : NO_WINNER;
      IX_SRCHI:  rdMux = pending[HALF +: HALF];
      IX_SRCLO:  rdMux = pending[0 +: HALF];
      IX_NPNDHI: rdMux = normFlags[HALF +: HALF];
      IX_NPNDLO: rdMux = normFlags[0 +: HALF];
      IX_FPNDHI: rdMux = fastFlags[HALF +: HALF];
      IX_FPNDLO: rdMux = fastFlags[0 +: HALF];
      IX_VECBASE: rdMux = VEC_BASE_VALUE;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= '0;
      enabled  <= '0;
      fastType <= '0;
      srcPrev  <= '0;
      ackPrev  <= '0;
      cntlReg  <= '0;
      maskReg  <= MASK_ALL;
      busRdata <= '0;
      for (int w = 0; w < NWORDS; w++) prioWord[w] <= '0;
    end else begin
      pending <= pNext;
      srcPrev <= srcLevel;
      ackPrev <= ackVec;
      if (stb.wrCntl)    cntlReg <= busWdata;
      if (stb.wrMask)    maskReg <= busWdata[MASK_W-1:0];
      if (stb.wrEnNum)   enabled[busWdata[SRC_W-1:0]] <= 1'b1;
      if (stb.wrDisNum)  enabled[busWdata[SRC_W-1:0]] <= 1'b0;
      if (stb.wrEnHi)    enabled[HALF +: HALF]  <= busWdata;
      if (stb.wrEnLo)    enabled[0 +: HALF]     <= busWdata;
      if (stb.wrTypeHi)  fastType[HALF +: HALF] <= busWdata;
      if (stb.wrTypeLo)  fastType[0 +: HALF]    <= busWdata;
      if (stb.wrPrio)    prioWord[wordSel]      <= busWdata;
      if (stb.rdEn)      busRdata <= rdMux;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [IDX_W-1:0]   busIdx,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               irqOut,
  output logic               fiqOut
);
  vicStrobes_t stb;

  vic_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busIdx (busIdx),
    .stb    (stb)
  );

  vic_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busIdx   (busIdx),
    .busWdata (busWdata),
    .srcLevel (srcLevel),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWr,
  input logic [7:0]  busIdx,
  input logic [31:0] busRdata,
  input logic        fiqOut
);
  wire rd = busSel && !busWr;

  AST_NUM_PORTS_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rd && (busIdx == 8'd2 || busIdx == 8'd3)) |=> busRdata == 32'd0); // R2
  AST_MASK_FIVE_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (rd && busIdx == 8'd1) |=> busRdata[31:5] == 27'd0); // R7
  AST_NVEC_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (rd && busIdx == 8'd16) |=> (busRdata == 32'hFFFF_FFFF ||
      (busRdata[31:22] == 10'd0 && busRdata[15:4] == 12'd0))); // R8
  AST_FVEC_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (rd && busIdx == 8'd17 && !fiqOut) |=> busRdata == 32'hFFFF_FFFF); // R9
  AST_FVEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rd && busIdx == 8'd17) |=> (busRdata == 32'hFFFF_FFFF || busRdata < 32'd64)); // R9
  AST_VEC_BASE_FOUR: assert property (@(posedge clk) disable iff (!rstN)
    (rd && busIdx == 8'd64) |=> busRdata == 32'd4); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!rd && $past(!rd)) |=> $stable(busRdata)); // R12
endmodule

bind irq_vector_ctrl vic_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busIdx   (busIdx),
  .busRdata (busRdata),
  .fiqOut   (fiqOut)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcLevel = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busIdx = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, fiqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] expQ [$];
  string       tagQ [$];
  logic        rdSeen = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .busSel(busSel), .busWr(busWr),
    .busIdx(busIdx), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic report(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the oldest expected item when read data lands
  always @(posedge clk) rdSeen <= busSel && !busWr && rstN;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) report("scoreboard underflow", 32'd1, 32'd0);
      else report(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  task automatic busWrite(logic [7:0] idx, logic [31:0] data);
    busSel = 1'b1; busWr = 1'b1; busIdx = idx; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(logic [7:0] idx, logic [31:0] exp, string tag);
    busSel = 1'b1; busWr = 1'b0; busIdx = idx;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    report("watchdog expired", 32'd1, 32'd0);
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    report("R1 irqOut", {31'd0, irqOut}, 32'd0);
    report("R1 fiqOut", {31'd0, fiqOut}, 32'd0);
    busRead(8'd1,  32'h1F, "R1 mask reset");
    busRead(8'd0,  32'h0,  "R1 control reset");
    busRead(8'd18, 32'h0,  "R1 pending reset");
    busRead(8'd15, 32'h0,  "R1 priority reset");
    // R2 number-indexed enable/disable
    busWrite(8'd2, 32'h45);
    busWrite(8'd2, 32'h20);
    busRead(8'd5, 32'h20, "R2 enable by number low");
    busRead(8'd4, 32'h1,  "R2 enable by number high");
    busRead(8'd2, 32'h0,  "R2 enable port reads zero");
    busRead(8'd3, 32'h0,  "R2 disable port reads zero");
    busWrite(8'd3, 32'h60);
    busRead(8'd4, 32'h0,  "R2 disable by number");
    // R3 half-word enable and type access
    busWrite(8'd4, 32'hA5A5_0000);
    busRead(8'd4, 32'hA5A5_0000, "R3 enable high");
    busRead(8'd5, 32'h20,        "R3 enable low untouched");
    busWrite(8'd4, 32'hFFFF_FFFF);
    busWrite(8'd5, 32'hFFFF_FFFF);
    busWrite(8'd7, 32'h100);
    busRead(8'd7, 32'h100, "R3 type low");
    busRead(8'd6, 32'h0,   "R3 type high");
    // R4 reversed priority words
    busWrite(8'd15, 32'h30);
    busWrite(8'd8,  32'h7000_0000);
    busRead(8'd15, 32'h30,        "R4 word for sources 0-7");
    busRead(8'd8,  32'h7000_0000, "R4 word for sources 56-63");
    busRead(8'd14, 32'h0,         "R4 neighbour word");
    // R5 force and source readback
    busWrite(8'd21, 32'h6);
    busRead(8'd19, 32'h6, "R5 source low after force");
    busRead(8'd21, 32'h0, "R5 force reads zero");
    busRead(8'd18, 32'h0, "R5 source high");
    // R7 threshold
    report("R7 irq with open mask", {31'd0, irqOut}, 32'd1);
    busWrite(8'd1, 32'h2);
    report("R7 irq prio 3 over mask 2", {31'd0, irqOut}, 32'd1);
    busWrite(8'd1, 32'hFFFF_FFE3);
    report("R7 irq prio 3 at mask 3", {31'd0, irqOut}, 32'd0);
    busRead(8'd1, 32'h3, "R7 mask five bits");
    busWrite(8'd1, 32'h10);
    report("R7 irq mask 0x10", {31'd0, irqOut}, 32'd0);
    busWrite(8'd1, 32'h3);
    // R10 read-only and filtered pending views
    busRead(8'd23, 32'h6, "R10 normal pending low");
    busRead(8'd25, 32'h0, "R10 fast pending low");
    busWrite(8'd23, 32'hFFFF);
    busWrite(8'd19, 32'h0);
    busRead(8'd23, 32'h6, "R10 normal pending write ignored");
    busRead(8'd19, 32'h6, "R10 source write ignored");
    // R8 normal vector
    busRead(8'd16, 32'h0001_0003, "R8 highest priority");
    busRead(8'd16, 32'h0002_0000, "R8 next winner");
    busRead(8'd16, 32'hFFFF_FFFF, "R8 none left");
    busRead(8'd19, 32'h0,         "R8 acknowledged bits cleared");
    busWrite(8'd21, 32'h18);
    busRead(8'd16, 32'h0004_0000, "R8 tie to higher number");
    busRead(8'd16, 32'h0003_0000, "R8 tie loser after");
    busWrite(8'd20, 32'h8000_0000);
    busWrite(8'd21, 32'h2);
    busRead(8'd16, 32'h003F_0007, "R8 source 63 priority 7");
    busRead(8'd19, 32'h2,         "R8 lower source kept");
    busRead(8'd18, 32'h0,         "R8 source 63 cleared");
    busWrite(8'd21, 32'h0);
    // R9 fast vector
    busWrite(8'd6, 32'h1);
    busWrite(8'd21, 32'h100);
    busWrite(8'd20, 32'h1);
    report("R9 fiq high", {31'd0, fiqOut}, 32'd1);
    busRead(8'd25, 32'h100, "R10 fast pending low");
    busRead(8'd24, 32'h1,   "R10 fast pending high");
    busRead(8'd22, 32'h0,   "R10 normal pending high excludes fast");
    busRead(8'd16, 32'hFFFF_FFFF, "R8 fast sources not normal");
    busRead(8'd17, 32'd8,   "R9 lowest fast source");
    busRead(8'd17, 32'd32,  "R9 next fast source");
    busRead(8'd17, 32'hFFFF_FFFF, "R9 none left");
    report("R9 fiq low", {31'd0, fiqOut}, 32'd0);
    // R11 vector region, R12 hold
    busRead(8'd64, 32'd4, "R11 vector base reads 4");
    idle(1);
    report("R12 read data held", busRdata, 32'd4);
    busWrite(8'd65, 32'h1F);
    busRead(8'd1, 32'h3, "R11 vector write not aliased to mask");
    busWrite(8'd84, 32'hFFFF_FFFF);
    busRead(8'd18, 32'h0, "R11 vector write not aliased to force");
    busRead(8'd65, 32'h0, "R11 unmapped read");
    // R6 hardware levels
    srcLevel[5] = 1'b1;
    idle(1);
    busRead(8'd19, 32'h20, "R6 rising level sets");
    srcLevel[5] = 1'b0;
    idle(1);
    busRead(8'd19, 32'h0, "R6 falling level clears");
    srcLevel[5] = 1'b1;
    idle(1);
    busRead(8'd16, 32'h0005_0000, "R6 ack of held source");
    busRead(8'd19, 32'h0,  "R6 cleared right after ack");
    busRead(8'd19, 32'h20, "R6 held level sets again");
    srcLevel[5] = 1'b0;
    idle(1);
    busRead(8'd19, 32'h0, "R6 released");
    // R6 acknowledge and rising level in the same cycle
    busWrite(8'd21, 32'h8);
    srcLevel[3] = 1'b1;
    busRead(8'd16, 32'h0003_0000, "R6 same-cycle ack winner");
    busRead(8'd19, 32'h0, "R6 ack wins over rise");
    busRead(8'd19, 32'h8, "R6 level returns next cycle");
    srcLevel[3] = 1'b0;
    idle(1);
    busRead(8'd19, 32'h0, "R6 final release");
    idle(3);
    finishRun();
  end
endmodule